// File: doc/BRIEF.md
# Grouped Bit-Plane Transfer Packer

This block sits in the data phase of a memory command on a narrow, full-duplex link. Each link transfer carries seven payload bits toward the block and four payload bits away from it, and both directions move on the same transfer strobe. The block translates between those transfers and whole memory units: 8-bit bytes, 10-bit decles or 16-bit words. The unit size and the unit count come from the command header, which is decoded elsewhere.

On the receive path the block collects units in groups of up to seven. The upper bits of every unit in a group arrive first, one or two transfers per unit. The low-order bit planes of the whole group follow in one to three trailing transfers. Because the group size is always "seven, or whatever is left", the stream carries no length fields. Finished units are handed out one per cycle after the group's final trailing transfer. On the send path the block asks for one unit at a time and shifts it out as 4-bit nibbles, lowest nibble first. In both directions it ends the transfer by requesting the closing 1010 handshake and reports whether the master's pattern matched.

Top module: `pkr_bitplane_packer`

## Requirements
- R1: Release of the synchronised reset leaves the block idle: `busy`, `unit_valid`, `unit_req` and `hs_req` are low and `tx_nib` is 4'b1111. A `start` pulse in idle takes `kind` (0 = byte, 1 = decle, 2 = word, 3 treated as byte), `len_m1` (unit count minus one) and `dir_out` (1 = send, 0 = receive).
- R2: Receiving bytes, each unit's first transfer carries bits 7:1 on `rx_data[6:0]`. One trailing transfer carries bit 0 of group unit i (i = 0..6) on `rx_data[i]`.
- R3: Receiving decles, each unit's transfer carries bits 9:3. The first trailer carries bit 2 of unit i on `rx_data[i]`. The next two trailers form a 14-bit word P = {second, first}, where P[2i] is bit 1 and P[2i+1] is bit 0 of unit i.
- R4: Receiving words, each unit sends bits 7:1 and then bits 15:9. Two trailers form P as in R3, with P[2i] holding bit 8 and P[2i+1] holding bit 0 of unit i.
- R5: A group holds seven units while more than seven remain, and otherwise exactly the units that remain.
- R6: In a short final group, trailer bit positions that belong to absent units have no effect on any released unit.
- R7: No unit of a group is released before its last trailer. Units are then presented in order on `unit_valid`/`unit_data`, one per cycle, starting in the cycle after the clock edge that took that trailer.
- R8: Sending, each unit loaded by `unit_wr` is presented on `tx_nib` as nibbles from lowest to highest, advancing after each `xfer`: two nibbles for a byte, three for a decle (the third is {2'b00, bits 9:8}) and four for a word. `unit_req` is high while the block waits for the next unit.
- R9: After the last unit in either direction, `hs_req` is high and `tx_nib` is 4'b1010. The next `xfer` raises `hs_done` in that same cycle, with `hs_ok` high exactly when `rx_data` is 7'b1010101. The block is then idle.
- R10: While receiving data, `tx_nib` stays at 4'b1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a data phase (accepted in idle) |
| dir_out | input | 1 | 1 = send units, 0 = receive units |
| kind | input | 2 | Unit size: 0 byte, 1 decle, 2 word |
| len_m1 | input | LEN_W | Unit count minus one |
| xfer | input | 1 | One link transfer completes this cycle |
| rx_data | input | 7 | Payload received with the transfer |
| tx_nib | output | 4 | Payload to send with the next transfer |
| unit_valid | output | 1 | A received unit is on `unit_data` |
| unit_data | output | 16 | Received unit, zero-extended |
| unit_req | output | 1 | Waiting for the next unit to send |
| unit_wr | input | 1 | Strobe for `unit_wdata` |
| unit_wdata | input | 16 | Unit to send |
| hs_req | output | 1 | Closing handshake pending |
| hs_done | output | 1 | Handshake transfer taken this cycle |
| hs_ok | output | 1 | Handshake pattern matched |
| busy | output | 1 | A data phase is in progress |

## Verification
Received units appear in the cycle after the edge that takes a group's last trailer and then follow one per cycle. The bench tracks, before every transfer, how many units must already have been released, and it collects `unit_valid` at every falling edge. A sent unit's first nibble is on `tx_nib` in the cycle after the `unit_wr` edge, and each later nibble appears after the next `xfer` edge, so each nibble is read at the falling edge just before the bench raises `xfer`. `hs_done` and `hs_ok` are combinational on `xfer` and are sampled in the handshake cycle itself; `busy` is checked one edge later.

// File: rtl/pkr_pkg.sv
package pkr_pkg;
  localparam int RX_W   = 7;   // payload bits per inbound transfer
  localparam int TX_W   = 4;   // payload bits per outbound transfer
  localparam int GRP    = RX_W; // one trailer bit position per group unit
  localparam int UNIT_W = 16;
  localparam int SLOT_W = $clog2(GRP + 1);

  localparam logic [1:0] K_BYTE  = 2'd0;
  localparam logic [1:0] K_DECLE = 2'd1;
  localparam logic [1:0] K_WORD  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_IN_MAIN, S_IN_TRAIL, S_IN_DRAIN, S_OUT_WAIT, S_OUT_SEND, S_HS
  } pkr_state_e;

  // index of the final trailing transfer of a group
  function automatic logic [1:0] last_trail(input logic [1:0] k);
    case (k)
      K_DECLE: return 2'd2;
      K_WORD:  return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // index of the final nibble of one unit
  function automatic logic [1:0] last_nib(input logic [1:0] k);
    case (k)
      K_DECLE: return 2'd2;
      K_WORD:  return 2'd3;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/pkr_unpack.sv
module pkr_unpack
  import pkr_pkg::*;
(
  input  logic                 clk,
  input  logic                 main_we,
  input  logic                 main_half,
  input  logic                 trail_we,
  input  logic [1:0]           trail_idx,
  input  logic [1:0]           kind,
  input  logic [SLOT_W-1:0]    wslot,
  input  logic [RX_W-1:0]      rx,
  input  logic [SLOT_W-1:0]    rslot,
  output logic [UNIT_W-1:0]    rdata
);
  logic [UNIT_W-1:0] grp_mem [GRP];
  logic [RX_W-1:0]   pair_lo;
  logic [2*RX_W-1:0] pair;

  assign pair  = {rx, pair_lo};
  assign rdata = grp_mem[rslot];

  always_ff @(posedge clk) begin
    if (main_we) begin
      case (kind)
        K_DECLE: grp_mem[wslot] <= {6'h00, rx, 3'b000};
        K_WORD: begin
          if (!main_half) grp_mem[wslot] <= {8'h00, rx, 1'b0};
          else            grp_mem[wslot][15:9] <= rx;
        end
        default: grp_mem[wslot] <= {8'h00, rx, 1'b0};
      endcase
    end
    if (trail_we) begin
      case (kind)
        K_DECLE: begin
          if (trail_idx == 2'd0) begin
            for (int i = 0; i < GRP; i++) grp_mem[i][2] <= rx[i];
          end else if (trail_idx == 2'd1) begin
            pair_lo <= rx;
          end else begin
            for (int i = 0; i < GRP; i++) begin
              grp_mem[i][1] <= pair[2*i];
              grp_mem[i][0] <= pair[2*i+1];
            end
          end
        end
        K_WORD: begin
          if (trail_idx == 2'd0) begin
            pair_lo <= rx;
          end else begin
            for (int i = 0; i < GRP; i++) begin
              grp_mem[i][8] <= pair[2*i];
              grp_mem[i][0] <= pair[2*i+1];
            end
          end
        end
        default: begin
          for (int i = 0; i < GRP; i++) grp_mem[i][0] <= rx[i];
        end
      endcase
    end
  end
endmodule

// File: rtl/pkr_nibbler.sv
module pkr_nibbler
  import pkr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [1:0]        kind,
  input  logic [UNIT_W-1:0] din,
  output logic [TX_W-1:0]   nib
);
  logic [UNIT_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      case (kind)
        K_DECLE: sh_d = {6'h00, din[9:0]};
        K_WORD:  sh_d = din;
        default: sh_d = {8'h00, din[7:0]};
      endcase
    end else if (shift) begin
      sh_d = {{TX_W{1'b0}}, sh_q[UNIT_W-1:TX_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (load || shift) sh_q <= sh_d;
  end

  assign nib = sh_q[TX_W-1:0];
endmodule

// File: rtl/pkr_bitplane_packer.sv
module pkr_bitplane_packer
  import pkr_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_out,
  input  logic [1:0]       kind,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             xfer,
  input  logic [6:0]       rx_data,
  output logic [3:0]       tx_nib,
  output logic             unit_valid,
  output logic [15:0]      unit_data,
  output logic             unit_req,
  input  logic             unit_wr,
  input  logic [15:0]      unit_wdata,
  output logic             hs_req,
  output logic             hs_done,
  output logic             hs_ok,
  output logic             busy
);
  localparam int REM_W = LEN_W + 1;
  localparam logic [RX_W-1:0] HS_PATTERN = 7'b1010101;
  localparam logic [TX_W-1:0] HS_REPLY   = 4'b1010;
  localparam logic [TX_W-1:0] TX_IDLE    = 4'b1111;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  function automatic logic [SLOT_W-1:0] grp_of(input logic [REM_W-1:0] r);
    return (r > REM_W'(GRP)) ? SLOT_W'(GRP) : r[SLOT_W-1:0];
  endfunction

  pkr_state_e        st_q, st_d;
  logic [1:0]        kind_q, kind_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [SLOT_W-1:0] grp_q, grp_d, slot_q, slot_d;
  logic              half_q, half_d;
  logic [1:0]        tr_q, tr_d, nib_q, nib_d;
  logic              main_we, trail_we, nb_load, nb_shift;
  logic [TX_W-1:0]   nb_out;

  always_comb begin
    st_d = st_q; kind_d = kind_q; rem_d = rem_q; grp_d = grp_q;
    slot_d = slot_q; half_d = half_q; tr_d = tr_q; nib_d = nib_q;
    main_we = 1'b0; trail_we = 1'b0; nb_load = 1'b0; nb_shift = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        kind_d = kind;
        rem_d  = REM_W'(len_m1) + REM_W'(1);
        grp_d  = grp_of(REM_W'(len_m1) + REM_W'(1));
        slot_d = '0; half_d = 1'b0; tr_d = 2'd0; nib_d = 2'd0;
        st_d   = dir_out ? S_OUT_WAIT : S_IN_MAIN;
      end
      S_IN_MAIN: if (xfer) begin
        main_we = 1'b1;
        if (kind_q == K_WORD && !half_q) begin
          half_d = 1'b1;
        end else begin
          half_d = 1'b0;
          if (slot_q == grp_q - SLOT_W'(1)) begin
            st_d = S_IN_TRAIL; tr_d = 2'd0;
          end else begin
            slot_d = slot_q + SLOT_W'(1);
          end
        end
      end
      S_IN_TRAIL: if (xfer) begin
        trail_we = 1'b1;
        if (tr_q == last_trail(kind_q)) begin
          st_d = S_IN_DRAIN; slot_d = '0;
        end else begin
          tr_d = tr_q + 2'd1;
        end
      end
      S_IN_DRAIN: begin
        rem_d = rem_q - REM_W'(1);
        if (slot_q == grp_q - SLOT_W'(1)) begin
          if (rem_q == REM_W'(1)) begin
            st_d = S_HS;
          end else begin
            st_d = S_IN_MAIN; slot_d = '0;
            grp_d = grp_of(rem_q - REM_W'(1));
          end
        end else begin
          slot_d = slot_q + SLOT_W'(1);
        end
      end
      S_OUT_WAIT: if (unit_wr) begin
        nb_load = 1'b1; nib_d = 2'd0; st_d = S_OUT_SEND;
      end
      S_OUT_SEND: if (xfer) begin
        nb_shift = 1'b1;
        if (nib_q == last_nib(kind_q)) begin
          rem_d = rem_q - REM_W'(1);
          st_d  = (rem_q == REM_W'(1)) ? S_HS : S_OUT_WAIT;
        end else begin
          nib_d = nib_q + 2'd1;
        end
      end
      S_HS: if (xfer) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= S_IDLE; kind_q <= K_BYTE; rem_q <= '0; grp_q <= '0;
      slot_q <= '0; half_q <= 1'b0; tr_q <= 2'd0; nib_q <= 2'd0;
    end else begin
      st_q <= st_d; kind_q <= kind_d; rem_q <= rem_d; grp_q <= grp_d;
      slot_q <= slot_d; half_q <= half_d; tr_q <= tr_d; nib_q <= nib_d;
    end
  end

  pkr_unpack u_unpack (
    .clk(clk), .main_we(main_we), .main_half(half_q), .trail_we(trail_we),
    .trail_idx(tr_q), .kind(kind_q), .wslot(slot_q), .rx(rx_data),
    .rslot(slot_q), .rdata(unit_data)
  );

  pkr_nibbler u_nib (
    .clk(clk), .rst_n(srst_n), .load(nb_load), .shift(nb_shift),
    .kind(kind_q), .din(unit_wdata), .nib(nb_out)
  );

  assign busy       = (st_q != S_IDLE);
  assign unit_valid = (st_q == S_IN_DRAIN);
  assign unit_req   = (st_q == S_OUT_WAIT);
  assign hs_req     = (st_q == S_HS);
  assign hs_done    = hs_req && xfer;
  assign hs_ok      = hs_done && (rx_data == HS_PATTERN);
  assign tx_nib     = (st_q == S_OUT_SEND) ? nb_out :
                      (st_q == S_HS)       ? HS_REPLY : TX_IDLE;

  // group size follows the remaining count
  assert_group_size_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == S_IN_MAIN) |-> (grp_q == grp_of(rem_q)));
  // a group starts draining only right after its last trailer
  assert_release_after_trail_R7: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(unit_valid) |-> ($past(st_q) == S_IN_TRAIL && $past(xfer)));
  assert_drain_slot_R7: assert property (@(posedge clk) disable iff (!srst_n)
    unit_valid |-> (slot_q < grp_q));
  assert_nib_range_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == S_OUT_SEND) |-> (nib_q <= last_nib(kind_q)));
  assert_hs_exit_R9: assert property (@(posedge clk) disable iff (!srst_n)
    hs_done |=> !busy);
endmodule

// File: tb/sim_pkr_bitplane_packer.sv
module sim_pkr_bitplane_packer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, dir_out, xfer, unit_wr;
  logic [1:0] kind;
  logic [4:0] len_m1;
  logic [6:0] rx_data;
  logic [15:0] unit_wdata;
  logic [3:0] tx_nib;
  logic unit_valid, unit_req, hs_req, hs_done, hs_ok, busy;
  logic [15:0] unit_data;

  pkr_bitplane_packer #(.LEN_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_out(dir_out), .kind(kind),
    .len_m1(len_m1), .xfer(xfer), .rx_data(rx_data), .tx_nib(tx_nib),
    .unit_valid(unit_valid), .unit_data(unit_data), .unit_req(unit_req),
    .unit_wr(unit_wr), .unit_wdata(unit_wdata), .hs_req(hs_req),
    .hs_done(hs_done), .hs_ok(hs_ok), .busy(busy)
  );

  int tests = 0, fails = 0, cyc = 0, ngot = 0, nx = 0;
  logic [15:0] units [64];
  logic [15:0] got   [64];
  logic [6:0]  xf    [256];
  int          xrel  [256];   // units released before this transfer
  int          xend  [256];   // units released once this transfer is taken

  // {kind[1:0], dir_out, len_m1[4:0], seed[7:0]}
  localparam logic [15:0] VEC [10] = '{
    {2'd0, 1'b0, 5'd6,  8'h11}, {2'd1, 1'b0, 5'd8,  8'h23},
    {2'd2, 1'b0, 5'd15, 8'h35}, {2'd0, 1'b0, 5'd0,  8'h47},
    {2'd1, 1'b0, 5'd2,  8'h59}, {2'd2, 1'b0, 5'd7,  8'h6B},
    {2'd1, 1'b0, 5'd31, 8'h7D}, {2'd0, 1'b1, 5'd3,  8'h8F},
    {2'd1, 1'b1, 5'd2,  8'h91}, {2'd2, 1'b1, 5'd1,  8'hA3}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) if (unit_valid && ngot < 64) begin
    got[ngot] = unit_data;
    ngot++;
  end

  function automatic logic [15:0] msk(input logic [1:0] k);
    return (k == 2'd1) ? 16'h03FF : (k == 2'd2) ? 16'hFFFF : 16'h00FF;
  endfunction

  task automatic make_units(input logic [1:0] k, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++)
      units[i] = (16'(seed) * 16'h9E37 + 16'(i) * 16'h3B5D ^ 16'(i << 9)) & msk(k);
  endtask

  // independent encoder built from R2..R6
  task automatic encode(input logic [1:0] k, input int n);
    int base = 0;
    nx = 0;
    while (base < n) begin
      int g = (n - base > 7) ? 7 : n - base;
      logic [6:0]  t;
      logic [13:0] p;
      for (int i = 0; i < g; i++) begin
        logic [15:0] u = units[base + i];
        if (k == 2'd1) begin xf[nx] = u[9:3]; nx++; end
        else if (k == 2'd2) begin xf[nx] = u[7:1]; nx++; xf[nx] = u[15:9]; nx++; end
        else begin xf[nx] = u[7:1]; nx++; end
      end
      t = 7'h7F; p = 14'h3FFF;   // absent-unit positions set to ones
      for (int i = 0; i < g; i++) begin
        logic [15:0] u = units[base + i];
        if (k == 2'd1) begin t[i] = u[2]; p[2*i] = u[1]; p[2*i+1] = u[0]; end
        else if (k == 2'd2) begin p[2*i] = u[8]; p[2*i+1] = u[0]; end
        else t[i] = u[0];
      end
      if (k == 2'd1) begin xf[nx] = t; nx++; xf[nx] = p[6:0]; nx++; xf[nx] = p[13:7]; nx++; end
      else if (k == 2'd2) begin xf[nx] = p[6:0]; nx++; xf[nx] = p[13:7]; nx++; end
      else begin xf[nx] = t; nx++; end
      for (int j = 0; j < nx; j++) if (xend[j] < 0) xrel[j] = base;
      xend[nx-1] = base + g;
      for (int j = 0; j < nx - 1; j++) if (xend[j] < 0) xend[j] = 0;
      base += g;
    end
  endtask

  task automatic pulse_start(input logic [1:0] k, input logic d, input logic [4:0] l);
    @(negedge clk); start = 1'b1; kind = k; dir_out = d; len_m1 = l;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_xfer(input logic [6:0] v);
    xfer = 1'b1; rx_data = v;
    @(negedge clk); xfer = 1'b0; rx_data = 7'h7F;
  endtask

  task automatic handshake(input logic [6:0] pat, input bit exp_ok);
    chk(hs_req == 1'b1 && tx_nib == 4'hA, "R9 handshake request", {hs_req, tx_nib}, {1'b1, 4'hA});
    xfer = 1'b1; rx_data = pat;
    #0.1;
    chk(hs_done == 1'b1 && hs_ok == exp_ok, "R9 handshake result", {hs_done, hs_ok}, {1'b1, exp_ok});
    @(negedge clk); xfer = 1'b0; rx_data = 7'h7F;
    chk(busy == 1'b0, "R9 idle after handshake", busy, 0);
  endtask

  task automatic run_in(input logic [1:0] k, input int n, input logic [7:0] seed);
    make_units(k, n, seed);
    for (int j = 0; j < 256; j++) begin xend[j] = -1; xrel[j] = 0; end
    encode(k, n);
    ngot = 0;
    pulse_start(k, 1'b0, 5'(n - 1));
    for (int j = 0; j < nx; j++) begin
      chk(tx_nib == 4'hF, "R10 tx all ones", tx_nib, 4'hF);
      if (xend[j] > 0) chk(ngot == xrel[j], "R7 no early release", ngot, xrel[j]);
      do_xfer(xf[j]);
      if (xend[j] > 0) chk(unit_valid == 1'b1, "R7 release next cycle", unit_valid, 1);
      repeat (8) @(negedge clk);
    end
    chk(ngot == n, "R5 unit count", ngot, n);
    for (int i = 0; i < n; i++)
      chk(got[i] === units[i], (k == 2'd0) ? "R2 byte unit" : (k == 2'd1) ? "R3 decle unit" : "R4 word unit",
          got[i], units[i]);
    handshake(7'b1010101, 1'b1);
  endtask

  task automatic run_out(input logic [1:0] k, input int n, input logic [7:0] seed, input logic [6:0] pat, input bit ok);
    int nn = (k == 2'd0) ? 2 : (k == 2'd1) ? 3 : 4;
    make_units(k, n, seed);
    pulse_start(k, 1'b1, 5'(n - 1));
    for (int i = 0; i < n; i++) begin
      int w = 0;
      logic [15:0] rebuilt = 16'h0;
      while (!unit_req && w < 50) begin @(negedge clk); w++; end
      chk(unit_req == 1'b1, "R8 unit request", unit_req, 1);
      unit_wr = 1'b1; unit_wdata = units[i] | ~msk(k);  // upper bits must be dropped
      @(negedge clk); unit_wr = 1'b0;
      for (int m = 0; m < nn; m++) begin
        rebuilt = rebuilt | (16'(tx_nib) << (4 * m));
        do_xfer(7'h7F);
        @(negedge clk);
      end
      chk(rebuilt === units[i], "R8 nibble stream", rebuilt, units[i]);
    end
    handshake(pat, ok);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; dir_out = 1'b0; kind = 2'd0; len_m1 = '0;
    xfer = 1'b0; rx_data = 7'h7F; unit_wr = 1'b0; unit_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && unit_valid == 0 && unit_req == 0 && hs_req == 0 && tx_nib == 4'hF,
        "R1 reset state", {busy, unit_valid, unit_req, hs_req, tx_nib}, {4'b0000, 4'hF});

    for (int v = 0; v < 10; v++) begin
      if (VEC[v][13] == 1'b0)
        run_in(VEC[v][15:14], int'(VEC[v][12:8]) + 1, VEC[v][7:0]);
      else
        run_out(VEC[v][15:14], int'(VEC[v][12:8]) + 1, VEC[v][7:0], 7'b1010101, 1'b1);
    end

    // R6: short group of three decles; absent positions driven to zeros instead
    make_units(2'd1, 3, 8'hC5);
    for (int j = 0; j < 256; j++) begin xend[j] = -1; xrel[j] = 0; end
    encode(2'd1, 3);
    for (int j = nx - 3; j < nx; j++) xf[j] = xf[j] & ((j == nx - 3) ? 7'h07 : (j == nx - 2) ? 7'h3F : 7'h00);
    ngot = 0;
    pulse_start(2'd1, 1'b0, 5'd2);
    for (int j = 0; j < nx; j++) begin do_xfer(xf[j]); repeat (8) @(negedge clk); end
    for (int i = 0; i < 3; i++) chk(got[i] === units[i], "R6 absent positions ignored", got[i], units[i]);
    handshake(7'b1010101, 1'b1);

    // R9: wrong handshake pattern reported as mismatch
    run_out(2'd0, 1, 8'hE1, 7'b0101010, 1'b0);

    // R8: decle third nibble upper bits are zero
    pulse_start(2'd1, 1'b1, 5'd0);
    @(negedge clk);
    unit_wr = 1'b1; unit_wdata = 16'hFFFF;
    @(negedge clk); unit_wr = 1'b0;
    do_xfer(7'h7F); do_xfer(7'h7F);
    chk(tx_nib == 4'h3, "R8 decle third nibble", tx_nib, 4'h3);
    do_xfer(7'h7F);
    handshake(7'b1010101, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule